// File: doc/BRIEF.md
# Bresenham Line Pixel Stepper

This block walks the pixels of a straight line, one coordinate per accepted handshake, from a start position. Driver software works out the Bresenham terms beforehand: a signed initial error, an axial constant added when only the major axis moves, and a diagonal constant added when both axes move. It also supplies a pixel count minus one and a three-bit octant code that picks the major axis and the sign of each axis step. On a start pulse the stepper latches all of this and presents the first pixel. It presents the next pixel each time the consumer accepts one.

Every pixel carries a write flag taken from a two-bit draw mode. The modes keep every pixel, drop the first pixel, drop the last pixel, or keep only the pixels that open a new row (an outline suitable for area filling). When the last pixel is accepted, the stepper drops busy and pulses done for one cycle. Its coordinate outputs then rest one step beyond the final pixel, where a following chained line begins.

Top module: `line_walker`

## Requirements
- R1: During reset and after it, busy, done and px_valid are 0 and px_x, px_y are 0.
- R2: A start pulse while idle latches all inputs. From the next cycle busy and px_valid are 1 and px_x/px_y equal start_x/start_y.
- R3: Each accepted pixel moves the major axis by one. If the current error is negative (sign bit set), the minor axis holds and k_axial is added to the error. Otherwise the minor axis also moves by one and k_diag is added.
- R4: Octant bit 0 set makes Y the major axis. Bit 1 set makes Y steps go by -1. Bit 2 set makes X steps go by -1. Coordinates are 16-bit two's complement and wrap.
- R5: Exactly line_len+1 pixels are presented for one start.
- R6: While px_valid is 1 and px_ready is 0, px_x, px_y and px_write hold, and px_valid stays 1.
- R7: draw_mode 0 sets px_write on every pixel. Mode 1 clears it on the first pixel only. Mode 2 clears it on the last pixel only. With line_len 0, modes 1 and 2 write nothing.
- R8: draw_mode 3 sets px_write on the first pixel, and on any pixel whose step into it changed Y.
- R9: Busy stays 1 through the cycle in which the final pixel is accepted and is 0 in the next cycle. Done is 1 for exactly that next cycle.
- R10: After completion, px_x/px_y hold the coordinate one step past the last pixel, as the R3 rule gives it.
- R11: A start pulse while busy is ignored. The running line's pixels and end point are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a line when idle |
| start_x | input | 16 | Start X, two's complement |
| start_y | input | 16 | Start Y, two's complement |
| err_init | input | 16 | Initial error term, signed |
| k_axial | input | 16 | Error increment for a major-only step, signed |
| k_diag | input | 16 | Error increment for a two-axis step, signed |
| line_len | input | 12 | Pixel count minus one |
| octant | input | 3 | bit0 Y major, bit1 Y negative, bit2 X negative |
| draw_mode | input | 2 | 0 all, 1 no first, 2 no last, 3 row outline |
| busy | output | 1 | Line in progress |
| done | output | 1 | One-cycle pulse after the final pixel |
| px_valid | output | 1 | Pixel coordinate valid |
| px_ready | input | 1 | Consumer accepts the pixel |
| px_x | output | 16 | Current X |
| px_y | output | 16 | Current Y |
| px_write | output | 1 | Pixel should be written |

## Verification
The hardest state to reach is a start pulse that arrives in the middle of a line while the consumer is stalling. In that case the reload path and the hold path act on the same cycle. The bench drives px_ready from a shift-register pattern, so stalls fall on varied pixels, including the first and the last. On one run it raises start with different parameters partway through, and the pixel stream and end point must still match the original line. Single-pixel lines under the drop-first and drop-last modes are covered separately, because there the first and last pixel are the same pixel.

// File: rtl/line_pkg.sv
package line_pkg;
   typedef enum logic [1:0] {
      DM_ALL        = 2'd0,
      DM_SKIP_FIRST = 2'd1,
      DM_SKIP_LAST  = 2'd2,
      DM_ROW_EDGE   = 2'd3
   } draw_mode_e;

   localparam int AXIS_X = 0;
   localparam int AXIS_Y = 1;
endpackage

// File: rtl/lw_axis.sv
module lw_axis #(
   parameter int CW = 16
) (
   input  logic [CW-1:0] pos_i,
   input  logic          move_i,
   input  logic          dec_i,
   output logic [CW-1:0] pos_o
);
   localparam logic [CW-1:0] ONE = CW'(1);

   always_comb begin
      if (!move_i)
         pos_o = pos_i;
      else if (dec_i)
         pos_o = pos_i - ONE;
      else
         pos_o = pos_i + ONE;
   end
endmodule

// File: rtl/lw_err.sv
module lw_err #(
   parameter int EW = 16
) (
   input  logic signed [EW-1:0] err_i,
   input  logic signed [EW-1:0] ka_i,
   input  logic signed [EW-1:0] kd_i,
   output logic                 diag_o,
   output logic signed [EW-1:0] err_o
);
   always_comb begin
      diag_o = ~err_i[EW-1];
      err_o  = diag_o ? (err_i + kd_i) : (err_i + ka_i);
   end
endmodule

// File: rtl/lw_write_gate.sv
module lw_write_gate
   import line_pkg::*;
#(
   parameter bit EDGE_EN = 1'b1
) (
   input  draw_mode_e mode_i,
   input  logic       first_i,
   input  logic       last_i,
   input  logic       ymov_i,
   output logic       wr_o
);
   logic edge_hit;

   generate
      if (EDGE_EN) begin : g_edge
         assign edge_hit = first_i | ymov_i;
      end else begin : g_no_edge
         assign edge_hit = 1'b1;
      end
   endgenerate

   always_comb begin
      unique case (mode_i)
         DM_ALL:        wr_o = 1'b1;
         DM_SKIP_FIRST: wr_o = ~first_i;
         DM_SKIP_LAST:  wr_o = ~last_i;
         DM_ROW_EDGE:   wr_o = edge_hit;
         default:       wr_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/line_walker.sv
module line_walker
   import line_pkg::*;
#(
   parameter int CW      = 16,
   parameter int EW      = 16,
   parameter int LW      = 12,
   parameter bit EDGE_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [CW-1:0]        start_x,
   input  logic [CW-1:0]        start_y,
   input  logic signed [EW-1:0] err_init,
   input  logic signed [EW-1:0] k_axial,
   input  logic signed [EW-1:0] k_diag,
   input  logic [LW-1:0]        line_len,
   input  logic [2:0]           octant,
   input  logic [1:0]           draw_mode,
   output logic                 busy,
   output logic                 done,
   output logic                 px_valid,
   input  logic                 px_ready,
   output logic [CW-1:0]        px_x,
   output logic [CW-1:0]        px_y,
   output logic                 px_write
);
   localparam int NAXIS = 2;

   generate
      if (CW < 4 || EW < 4 || LW < 1) begin : g_bad_width
         $error("line_walker: CW and EW must be at least 4, LW at least 1");
      end
   endgenerate

   logic                 busy_q, done_q, first_q, ymov_q;
   logic [2:0]           oct_q;
   draw_mode_e           mode_q;
   logic [CW-1:0]        pos_q   [NAXIS];
   logic [CW-1:0]        pos_nxt [NAXIS];
   logic signed [EW-1:0] err_q, ka_q, kd_q, err_nxt;
   logic [LW-1:0]        cnt_q;
   logic                 diag, accept, last;
   logic [NAXIS-1:0]     mv, dec;

   assign accept = busy_q & px_ready;
   assign last   = (cnt_q == '0);

   lw_err #(.EW(EW)) u_err (
      .err_i (err_q),
      .ka_i  (ka_q),
      .kd_i  (kd_q),
      .diag_o(diag),
      .err_o (err_nxt)
   );

   assign mv[AXIS_X]  = ~oct_q[0] | diag;
   assign mv[AXIS_Y]  =  oct_q[0] | diag;
   assign dec[AXIS_X] =  oct_q[2];
   assign dec[AXIS_Y] =  oct_q[1];

   genvar a;
   generate
      for (a = 0; a < NAXIS; a++) begin : g_axis
         lw_axis #(.CW(CW)) u_axis (
            .pos_i (pos_q[a]),
            .move_i(mv[a]),
            .dec_i (dec[a]),
            .pos_o (pos_nxt[a])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         first_q  <= 1'b0;
         ymov_q   <= 1'b0;
         oct_q    <= '0;
         mode_q   <= DM_ALL;
         pos_q[0] <= '0;
         pos_q[1] <= '0;
         err_q    <= '0;
         ka_q     <= '0;
         kd_q     <= '0;
         cnt_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q && start) begin
            busy_q   <= 1'b1;
            first_q  <= 1'b1;
            ymov_q   <= 1'b0;
            oct_q    <= octant;
            mode_q   <= draw_mode_e'(draw_mode);
            pos_q[0] <= start_x;
            pos_q[1] <= start_y;
            err_q    <= err_init;
            ka_q     <= k_axial;
            kd_q     <= k_diag;
            cnt_q    <= line_len;
         end else if (accept) begin
            pos_q[0] <= pos_nxt[0];
            pos_q[1] <= pos_nxt[1];
            err_q    <= err_nxt;
            first_q  <= 1'b0;
            ymov_q   <= mv[AXIS_Y];
            cnt_q    <= cnt_q - 1'b1;
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   lw_write_gate #(.EDGE_EN(EDGE_EN)) u_wr (
      .mode_i (mode_q),
      .first_i(first_q),
      .last_i (last),
      .ymov_i (ymov_q),
      .wr_o   (px_write)
   );

   assign busy     = busy_q;
   assign done     = done_q;
   assign px_valid = busy_q;
   assign px_x     = pos_q[0];
   assign px_y     = pos_q[1];
endmodule

// File: rtl/lw_checker.sv
module lw_checker #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          px_valid,
   input logic          px_ready,
   input logic [CW-1:0] px_x,
   input logic [CW-1:0] px_y,
   input logic          px_write,
   input logic [2:0]    oct_q
);
   localparam logic [CW-1:0] ONE = CW'(1);

   AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid && !px_ready |=> px_valid && $stable(px_x) && $stable(px_y) && $stable(px_write)); // R6

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9

   AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(px_valid && px_ready)); // R9

   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R2

   AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start && !px_ready |=> $stable(px_x) && $stable(px_y)); // R11

   AST_X_MAJOR_INC: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid && px_ready && oct_q == 3'b000 |=> (px_x - $past(px_x)) == ONE); // R3

   AST_Y_MAJOR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid && px_ready && oct_q == 3'b011 |=> ($past(px_y) - px_y) == ONE); // R4
endmodule

bind line_walker lw_checker #(.CW(CW)) u_lw_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .px_valid(px_valid),
   .px_ready(px_ready),
   .px_x    (px_x),
   .px_y    (px_y),
   .px_write(px_write),
   .oct_q   (oct_q)
);

// File: tb/tb_line_walker.sv
module tb_line_walker;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 10;

   typedef struct packed {
      logic [2:0]         oct;
      logic [1:0]         mode;
      logic signed [15:0] sx;
      logic signed [15:0] sy;
      logic signed [15:0] err;
      logic signed [15:0] ka;
      logic signed [15:0] kd;
      logic [11:0]        len;
      logic signed [15:0] ex;
      logic signed [15:0] ey;
      logic [7:0]         nw;
   } vec_t;

   // oct, mode, sx, sy, err, ka, kd, len, end x, end y, written pixels
   localparam vec_t VECS [NVEC] = '{
      '{3'd0, 2'd0, 16'sd100, 16'sd100, 16'sd0,  16'sd4, -16'sd4, 12'd4, 16'sd105, 16'sd103, 8'd5},
      '{3'd6, 2'd1, 16'sd100, 16'sd100, 16'sd0,  16'sd4, -16'sd4, 12'd4, 16'sd95,  16'sd97,  8'd4},
      '{3'd1, 2'd2, 16'sd100, 16'sd100, -16'sd1, 16'sd2, -16'sd4, 12'd3, 16'sd101, 16'sd104, 8'd3},
      '{3'd0, 2'd3, 16'sd100, 16'sd100, 16'sd0,  16'sd4, -16'sd4, 12'd4, 16'sd105, 16'sd103, 8'd3},
      '{3'd2, 2'd1, 16'sd5,   16'sd5,   16'sd0,  16'sd4, -16'sd4, 12'd0, 16'sd6,   16'sd4,   8'd0},
      '{3'd2, 2'd2, 16'sd5,   16'sd5,   16'sd0,  16'sd4, -16'sd4, 12'd0, 16'sd6,   16'sd4,   8'd0},
      '{3'd4, 2'd0, 16'sd100, 16'sd100, -16'sd3, 16'sd0, -16'sd6, 12'd3, 16'sd96,  16'sd100, 8'd4},
      '{3'd5, 2'd0, -16'sd3,  -16'sd2,  16'sd2,  16'sd4, 16'sd0,  12'd2, -16'sd6,  16'sd1,   8'd3},
      '{3'd1, 2'd3, 16'sd100, 16'sd100, -16'sd1, 16'sd2, -16'sd4, 12'd3, 16'sd101, 16'sd104, 8'd4},
      '{3'd6, 2'd3, 16'sd100, 16'sd100, 16'sd0,  16'sd4, -16'sd4, 12'd4, 16'sd95,  16'sd97,  8'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] start_x = '0, start_y = '0;
   logic signed [15:0] err_init = '0, k_axial = '0, k_diag = '0;
   logic [11:0] line_len = '0;
   logic [2:0]  octant = '0;
   logic [1:0]  draw_mode = '0;
   logic        px_ready = 1'b0;
   logic        busy, done, px_valid, px_write;
   logic [15:0] px_x, px_y;

   int checks = 0;
   int failures = 0;
   logic [7:0] lfsr = 8'hA5;

   always #(CLK_PERIOD/2) clk = ~clk;

   line_walker dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_x(start_x), .start_y(start_y),
      .err_init(err_init), .k_axial(k_axial), .k_diag(k_diag), .line_len(line_len),
      .octant(octant), .draw_mode(draw_mode), .busy(busy), .done(done),
      .px_valid(px_valid), .px_ready(px_ready), .px_x(px_x), .px_y(px_y),
      .px_write(px_write)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_line(input vec_t v, input bit inject);
      logic signed [15:0] mx, my, me;
      bit ymv, diag, rdy, exp_wr, stalled;
      int idx, nw;
      @(negedge clk);
      start_x = v.sx; start_y = v.sy; err_init = v.err; k_axial = v.ka; k_diag = v.kd;
      line_len = v.len; octant = v.oct; draw_mode = v.mode; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy && px_valid && px_x == v.sx && px_y == v.sy, "R2 load",
            {busy, px_valid, px_x[13:0], px_y[15:0]}, {2'b11, v.sx[13:0], v.sy});
      mx = v.sx; my = v.sy; me = v.err; idx = 0; nw = 0; ymv = 1'b0; stalled = 1'b0;
      while (idx <= int'(v.len)) begin
         if (stalled)
            check(px_valid && px_x == mx && px_y == my, "R6 hold", {px_x, px_y}, {mx, my});
         start = (inject && idx == 2);
         if (start) begin
            start_x = 16'h0; start_y = 16'h0; octant = ~v.oct; err_init = -16'sd7;
         end
         rdy = lfsr[0] | lfsr[1];
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         px_ready = rdy;
         stalled = !rdy;
         if (rdy) begin
            case (v.mode)
               2'd0: exp_wr = 1'b1;
               2'd1: exp_wr = (idx != 0);
               2'd2: exp_wr = (idx != int'(v.len));
               default: exp_wr = (idx == 0) || ymv;
            endcase
            check(px_valid && px_x == mx && px_y == my,
                  inject ? "R11 pixel" : "R3 R4 pixel", {px_x, px_y}, {mx, my});
            check(px_write == exp_wr, (v.mode == 2'd3) ? "R8 write" : "R7 write",
                  32'(px_write), 32'(exp_wr));
            if (px_write) nw++;
            diag = (me >= 0);
            if (!v.oct[0] || diag) mx = v.oct[2] ? mx - 16'sd1 : mx + 16'sd1;
            if (v.oct[0] || diag)  my = v.oct[1] ? my - 16'sd1 : my + 16'sd1;
            ymv = v.oct[0] || diag;
            me = diag ? me + v.kd : me + v.ka;
            idx++;
         end
         @(negedge clk);
      end
      px_ready = 1'b0; start = 1'b0;
      check(!busy && done, "R9 R5 end", {busy, done}, 2'b01);
      check(px_x == v.ex && px_y == v.ey && mx == v.ex && my == v.ey,
            inject ? "R11 end point" : "R10 end point", {px_x, px_y}, {v.ex, v.ey});
      check(nw == int'(v.nw), (v.mode == 2'd3) ? "R8 count" : "R7 count", nw, v.nw);
      @(negedge clk);
      check(!done && !busy, "R9 done pulse", {busy, done}, 2'b00);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !px_valid && px_x == 0 && px_y == 0, "R1 reset",
            {busy, done, px_valid, px_x, px_y}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !px_valid, "R1 idle after reset", {busy, px_valid}, 0);

      for (int i = 0; i < NVEC; i++) run_line(VECS[i], 1'b0);

      // R11: start pulse mid-line with different parameters
      run_line(VECS[0], 1'b1);
      run_line(VECS[7], 1'b1);

      // R1: reset during a line
      @(negedge clk);
      start_x = 16'd9; start_y = 16'd9; line_len = 12'd20; octant = 3'd0; draw_mode = 2'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      check(!busy && !px_valid && !done && px_x == 0 && px_y == 0, "R1 mid-line reset",
            {busy, px_valid, done, px_x, px_y}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule